// File: doc/BRIEF.md
# Programmable Serial Audio Frame Engine

This block is a master-side serial port for audio samples. It produces a bit clock, a frame strobe and a serial data line, and it samples a serial input line. Frame shape comes from a set of static configuration inputs: idle clocks ahead of the data, sample width, trailing stop clocks, where the strobe begins and how long it lasts, its polarity, one of four clock edge and idle arrangements, and the state of the data line once the sample has been sent.

Samples to send go into an eight-entry transmit queue. Received samples go into an eight-entry receive queue. Once enabled, and once the transmit queue holds a word, the engine sends frames back to back until it is disabled. Each frame takes one word from the queue. If no word is waiting when a frame starts, the frame carries zeros and a sticky flag records the event. A received word that finds the receive queue full is dropped, and a second sticky flag records that. Configuration must be held constant while the engine is enabled.

Top module: `audio_frame_engine`

## Requirements
- R1: The sample width is size_code+1, plus 16 when size_ext is 1, for a range of 1 to 32 bits. Each word leaves on txd right-aligned and most significant bit first. One bit is sent per serial clock period and stays stable across that whole period.
- R2: clk_mode selects the serial clock behaviour. With 0, the clock idles low and is low in the first half of each bit (data changes on falling edges, sampled on rising edges). With 1, it idles low and is high in the first half. With 2, it idles high and is high in the first half. With 3, it idles high and is low in the first half.
- R3: A frame consists of start_dly idle clock periods, then the data bits, then {stop_hi,stop_lo} stop clock periods (0 to 31). The next frame begins directly after. A frame therefore lasts 2*(start+width+stop) half periods, and each half period lasts HALF_DIV system clocks.
- R4: When fs_active_high is 1 the frame strobe is active high. When it is 0 the strobe is active low.
- R5: With fs_rel_lsb at 0, the strobe becomes active fs_dly half periods after the frame begins, provided that point lies inside the frame. It then stays active for 2*fs_width half periods and may extend into the next frame. A fs_width of 0 gives no strobe.
- R6: With fs_rel_lsb at 1, the stop clocks are skipped and fs_dly is ignored. The strobe becomes active at the start of each frame's last data bit, for 2*fs_width half periods.
- R7: Outside the data bits, txd is 0 when eot_hold is 0. When eot_hold is 1, txd holds the last bit that was sent (0 after reset).
- R8: rxd is sampled at the start of the second half of each data bit. After the last bit, the word is pushed into the receive queue right-aligned with the upper bits zero. rx_data shows the oldest entry, and rx_level counts the entries.
- R9: While enable is 0, sclk sits at its idle level, the strobe is inactive and busy is 0. Once enabled, the first frame begins on the first clock on which the transmit queue holds a word, and busy stays 1 until the engine is disabled.
- R10: If the transmit queue is empty when a frame begins, that frame sends zeros and tx_underrun is set. The flag stays set until clr_underrun is pulsed.
- R11: A received word that finds the receive queue full (8 entries) is discarded and sets rx_overrun. The flag stays set until clr_overrun is pulsed.
- R12: The transmit queue holds 8 words, and tx_level reports how many. tx_not_full is 0 while the queue is full, and a push into a full queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the engine when 1 |
| clk_mode | input | 2 | Serial clock edge and idle arrangement |
| fs_active_high | input | 1 | Strobe polarity |
| start_dly | input | 3 | Idle clocks ahead of the data |
| fs_dly | input | 7 | Strobe start, in half periods from frame start |
| fs_width | input | 6 | Strobe length in clock periods |
| stop_lo | input | 2 | Stop clock count, low part |
| stop_hi | input | 3 | Stop clock count, high part |
| eot_hold | input | 1 | Hold the last bit on txd after the data |
| fs_rel_lsb | input | 1 | Strobe timed from the last data bit, no stop clocks |
| size_code | input | 4 | Sample width minus one (low part) |
| size_ext | input | 1 | Adds 16 to the sample width |
| tx_data | input | 32 | Word to queue for sending |
| tx_push | input | 1 | Writes tx_data into the transmit queue |
| tx_not_full | output | 1 | Transmit queue has room |
| tx_level | output | 4 | Words in the transmit queue |
| tx_underrun | output | 1 | Sticky: a frame began with an empty queue |
| clr_underrun | input | 1 | Clears tx_underrun |
| rx_data | output | 32 | Oldest received word |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_not_empty | output | 1 | Receive queue holds a word |
| rx_level | output | 4 | Words in the receive queue |
| rx_overrun | output | 1 | Sticky: a received word was dropped |
| clr_overrun | input | 1 | Clears rx_overrun |
| busy | output | 1 | Frames are running |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame strobe |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The serial output is looped back into rxd, so every run checks the sent waveform half period by half period and also checks the words read back from the receive queue. Directed runs cover each clock mode, both strobe polarities, both strobe timing references, a zero strobe width and sample widths of 1, 17 and 32. Between them these runs distinguish a wrong bit order, a wrong edge assignment, a misplaced strobe and mishandled stop clocks. Seeded random configurations then mix all fields, including strobe windows that spill into the next frame. A final run pushes nine words and plays nine frames, which separates the ignored push into a full transmit queue from the underrun and the overrun that follow.

// File: rtl/afe_pkg.sv
package afe_pkg;

  // sample width in bits: 1..32
  function automatic logic [5:0] word_bits(input logic [3:0] code, input logic ext);
    return {1'b0, ext, code} + 6'd1;
  endfunction

  // frame length in half periods of the serial clock
  function automatic logic [7:0] frame_halves(input logic [2:0] s, input logic [5:0] w,
                                              input logic [4:0] d);
    return {4'b0, s, 1'b0} + {1'b0, w, 1'b0} + {2'b0, d, 1'b0};
  endfunction

  // half-period index where the last data bit begins
  function automatic logic [7:0] lsb_half(input logic [2:0] s, input logic [5:0] w);
    return {4'b0, s, 1'b0} + {1'b0, w, 1'b0} - 8'd2;
  endfunction

  function automatic logic [31:0] word_mask(input logic [5:0] w);
    return w[5] ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // serial clock level in the first half of a bit
  function automatic logic first_half_high(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction

endpackage

// File: rtl/afe_fifo.sv
module afe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // a push into a full queue leaves the level unchanged
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> count == $past(count));
  // R8: popping an empty queue keeps it empty
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty);

endmodule

// File: rtl/afe_frame_seq.sv
module afe_frame_seq
  import afe_pkg::*;
#(
  parameter int HALF_DIV = 2,
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       can_start,
  input  logic [2:0] start_clks,
  input  logic [5:0] nbits,
  input  logic [4:0] stop_clks,
  input  logic [6:0] fs_dly,
  input  logic [5:0] fs_width,
  input  logic       fs_rel_lsb,
  output logic       running,
  output logic       half_odd,
  output logic       frame_start,
  output logic       sample_evt,
  output logic       in_data,
  output logic [4:0] bit_idx,
  output logic       fs_act
);
  logic [DIV_W-1:0] div_q;
  logic [7:0]       hcnt_q, len, trig, new_h, data_lo, data_hi, rel_h;
  logic [6:0]       fs_cnt_q, fs_load;
  logic             running_q, tick, trig_ok;

  always_comb begin
    len     = frame_halves(start_clks, nbits, fs_rel_lsb ? 5'd0 : stop_clks);
    trig    = fs_rel_lsb ? lsb_half(start_clks, nbits) : {1'b0, fs_dly};
    trig_ok = trig < len;
    fs_load = {fs_width, 1'b0};
    data_lo = {4'b0, start_clks, 1'b0};
    data_hi = data_lo + {1'b0, nbits, 1'b0};
    rel_h   = hcnt_q - data_lo;
    tick    = running_q && (div_q == DIV_W'(HALF_DIV - 1));
    new_h   = (hcnt_q == len - 8'd1) ? 8'd0 : hcnt_q + 8'd1;
  end

  // named events shared with the datapath and the assertions
  assign running     = running_q;
  assign half_odd    = hcnt_q[0];
  assign in_data     = running_q && (hcnt_q >= data_lo) && (hcnt_q < data_hi);
  assign bit_idx     = rel_h[5:1];
  assign sample_evt  = tick && in_data && !hcnt_q[0];
  assign fs_act      = (fs_cnt_q != 7'd0);
  assign frame_start = enable && (running_q ? (tick && new_h == 8'd0) : can_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      hcnt_q    <= '0;
      div_q     <= '0;
      fs_cnt_q  <= '0;
    end else if (!enable) begin
      running_q <= 1'b0;
      hcnt_q    <= '0;
      div_q     <= '0;
      fs_cnt_q  <= '0;
    end else if (!running_q) begin
      if (can_start) begin
        running_q <= 1'b1;
        hcnt_q    <= '0;
        div_q     <= '0;
        fs_cnt_q  <= (trig_ok && trig == 8'd0) ? fs_load : 7'd0;
      end
    end else if (tick) begin
      hcnt_q <= new_h;
      div_q  <= '0;
      if (trig_ok && new_h == trig) fs_cnt_q <= fs_load;
      else if (fs_cnt_q != 7'd0)    fs_cnt_q <= fs_cnt_q - 7'd1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R8: rx sampling happens as the bit enters its second half
  assert_sample_mid_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt && enable |=> hcnt_q[0]);
  // R3: a frame boundary while running restarts the half-period count
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && frame_start |=> hcnt_q == 8'd0);
  // R9: disabling stops the sequencer and drops the strobe
  assert_stop_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running_q && !fs_act);

endmodule

// File: rtl/audio_frame_engine.sv
module audio_frame_engine
  import afe_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       clk_mode,
  input  logic             fs_active_high,
  input  logic [2:0]       start_dly,
  input  logic [6:0]       fs_dly,
  input  logic [5:0]       fs_width,
  input  logic [1:0]       stop_lo,
  input  logic [2:0]       stop_hi,
  input  logic             eot_hold,
  input  logic             fs_rel_lsb,
  input  logic [3:0]       size_code,
  input  logic             size_ext,
  input  logic [31:0]      tx_data,
  input  logic             tx_push,
  output logic             tx_not_full,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_underrun,
  input  logic             clr_underrun,
  output logic [31:0]      rx_data,
  input  logic             rx_pop,
  output logic             rx_not_empty,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_overrun,
  input  logic             clr_overrun,
  output logic             busy,
  output logic             sclk,
  output logic             fsync,
  output logic             txd,
  input  logic             rxd
);
  logic [5:0]  nbits;
  logic [4:0]  msb_idx, tx_idx, bit_idx;
  logic [31:0] tx_head, tx_word_q, rx_sh_q, rx_next, rx_word;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        running, half_odd, frame_start, sample_evt, in_data, fs_act;
  logic        tx_bit, last_bit_q, rx_push, underrun_q, overrun_q;

  assign nbits   = word_bits(size_code, size_ext);
  assign msb_idx = nbits[4:0] - 5'd1;
  assign tx_idx  = msb_idx - bit_idx;
  assign tx_bit  = tx_word_q[tx_idx];
  assign rx_next = {rx_sh_q[30:0], rxd};
  assign rx_word = rx_next & word_mask(nbits);
  assign rx_push = sample_evt && (bit_idx == msb_idx);

  afe_frame_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .can_start(!tx_empty),
    .start_clks(start_dly), .nbits(nbits), .stop_clks({stop_hi, stop_lo}),
    .fs_dly(fs_dly), .fs_width(fs_width), .fs_rel_lsb(fs_rel_lsb),
    .running(running), .half_odd(half_odd), .frame_start(frame_start),
    .sample_evt(sample_evt), .in_data(in_data), .bit_idx(bit_idx), .fs_act(fs_act)
  );

  afe_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
    .pop(frame_start && !tx_empty), .dout(tx_head), .count(tx_level),
    .full(tx_full), .empty(tx_empty)
  );

  afe_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .count(rx_level),
    .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word_q  <= '0;
      last_bit_q <= 1'b0;
      rx_sh_q    <= '0;
      underrun_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      if (frame_start) tx_word_q <= tx_empty ? 32'd0 : tx_head;
      if (in_data)     last_bit_q <= tx_bit;
      if (sample_evt)  rx_sh_q <= rx_next;
      if (frame_start && tx_empty) underrun_q <= 1'b1;
      else if (clr_underrun)       underrun_q <= 1'b0;
      if (rx_push && rx_full)      overrun_q <= 1'b1;
      else if (clr_overrun)        overrun_q <= 1'b0;
    end
  end

  assign sclk         = running ? (half_odd ^ first_half_high(clk_mode)) : clk_mode[1];
  assign fsync        = ~(fs_act ^ fs_active_high);
  assign txd          = in_data ? tx_bit : (eot_hold & last_bit_q);
  assign busy         = running;
  assign tx_not_full  = !tx_full;
  assign rx_not_empty = !rx_empty;
  assign tx_underrun  = underrun_q;
  assign rx_overrun   = overrun_q;

  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> sclk == clk_mode[1] && fsync == !fs_active_high && !busy);
  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun && !clr_underrun |=> tx_underrun);
  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !clr_overrun |=> rx_overrun);

endmodule

// File: tb/audio_frame_engine_tb.sv
module audio_frame_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HD         = 2;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0]  clk_mode = '0;
  logic        fs_active_high = 1'b0, eot_hold = 1'b0, fs_rel_lsb = 1'b0, size_ext = 1'b0;
  logic [2:0]  start_dly = '0, stop_hi = '0;
  logic [6:0]  fs_dly = '0;
  logic [5:0]  fs_width = '0;
  logic [1:0]  stop_lo = '0;
  logic [3:0]  size_code = '0;
  logic [31:0] tx_data = '0;
  logic        tx_push = 1'b0, rx_pop = 1'b0, clr_underrun = 1'b0, clr_overrun = 1'b0;
  logic        tx_not_full, tx_underrun, rx_not_empty, rx_overrun, busy, sclk, fsync, txd, rxd;
  logic [3:0]  tx_level, rx_level;
  logic [31:0] rx_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] words [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxd = txd;  // loopback

  audio_frame_engine #(.HALF_DIV(HD), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_mode(clk_mode),
    .fs_active_high(fs_active_high), .start_dly(start_dly), .fs_dly(fs_dly),
    .fs_width(fs_width), .stop_lo(stop_lo), .stop_hi(stop_hi), .eot_hold(eot_hold),
    .fs_rel_lsb(fs_rel_lsb), .size_code(size_code), .size_ext(size_ext),
    .tx_data(tx_data), .tx_push(tx_push), .tx_not_full(tx_not_full), .tx_level(tx_level),
    .tx_underrun(tx_underrun), .clr_underrun(clr_underrun), .rx_data(rx_data),
    .rx_pop(rx_pop), .rx_not_empty(rx_not_empty), .rx_level(rx_level),
    .rx_overrun(rx_overrun), .clr_overrun(clr_overrun), .busy(busy), .sclk(sclk),
    .fsync(fsync), .txd(txd), .rxd(rxd)
  );

  function automatic int exp_bits(input logic [3:0] code, input logic ext);
    return int'(code) + 1 + (ext ? 16 : 0);
  endfunction
  function automatic int exp_len(input int s, input int w, input int d, input logic rel);
    return rel ? 2 * (s + w) : 2 * (s + w + d);
  endfunction
  function automatic int exp_trig(input int s, input int w, input int dly, input logic rel);
    return rel ? 2 * (s + w) - 2 : dly;
  endfunction
  function automatic logic [31:0] exp_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    enable = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int mode, input bit pol, input int s, input int fdly,
                         input int fw, input int dlo, input int dhi, input bit eot,
                         input bit rel, input int code, input bit ext);
    clk_mode = 2'(mode); fs_active_high = pol; start_dly = 3'(s); fs_dly = 7'(fdly);
    fs_width = 6'(fw); stop_lo = 2'(dlo); stop_hi = 3'(dhi); eot_hold = eot;
    fs_rel_lsb = rel; size_code = 4'(code); size_ext = ext;
  endtask

  // resets, queues npush words, plays nfr frames and checks every half period
  task automatic run_stream(input int nfr, input int npush, input string tag);
    int w, s, d, len, trig, nw, ds, nrx, fw;
    int bad_s, bad_f, bad_t, bad_b;
    logic fa_s, fe_s, fa_f, fe_f, fa_t, fe_t, inv;
    logic [31:0] msk;
    w = exp_bits(size_code, size_ext); s = int'(start_dly);
    d = int'({stop_hi, stop_lo}); fw = int'(fs_width);
    len = exp_len(s, w, d, fs_rel_lsb); trig = exp_trig(s, w, int'(fs_dly), fs_rel_lsb);
    nw = (npush < DEPTH) ? npush : DEPTH; ds = 2 * s; msk = exp_mask(w);
    inv = (clk_mode == 2'd1) || (clk_mode == 2'd2);
    bad_s = 0; bad_f = 0; bad_t = 0; bad_b = 0;
    fa_s = 0; fe_s = 0; fa_f = 0; fe_f = 0; fa_t = 0; fe_t = 0;
    do_reset();
    for (int i = 0; i < npush; i++) begin
      words[i] = $urandom;
      tx_data = words[i]; tx_push = 1'b1;
      @(negedge clk);
      tx_push = 1'b0;
    end
    chk(tx_level == 4'(nw), "R12", {tag, " tx_level"}, tx_level, nw);
    chk(tx_not_full == (nw < DEPTH), "R12", {tag, " tx_not_full"}, tx_not_full, nw < DEPTH);
    enable = 1'b1;
    for (int g = 0; g < nfr * len; g++) begin
      int f, h;
      logic [31:0] wf, wp;
      logic es, ef, et, act;
      @(negedge clk);
      f = g / len; h = g % len;
      wf = (f < nw) ? words[f] : 32'd0;
      wp = (f > 0 && f - 1 < nw) ? words[f - 1] : 32'd0;
      es = ((h % 2) == 1) ^ inv;
      act = 1'b0;
      for (int fp = 0; fp <= f; fp++) begin
        int t;
        t = fp * len + trig;
        if (trig < len && g >= t && g < t + 2 * fw) act = 1'b1;
      end
      ef = act ? fs_active_high : !fs_active_high;
      if (h >= ds && h < ds + 2 * w) et = wf[w - 1 - (h - ds) / 2];
      else if (!eot_hold)            et = 1'b0;
      else if (h >= ds + 2 * w)      et = wf[0];
      else                           et = (f > 0) ? wp[0] : 1'b0;
      if (sclk !== es)  begin if (bad_s == 0) begin fa_s = sclk;  fe_s = es; end bad_s++; end
      if (fsync !== ef) begin if (bad_f == 0) begin fa_f = fsync; fe_f = ef; end bad_f++; end
      if (txd !== et)   begin if (bad_t == 0) begin fa_t = txd;   fe_t = et; end bad_t++; end
      if (busy !== 1'b1) bad_b++;
      repeat (HD - 1) @(negedge clk);
    end
    enable = 1'b0;
    chk(bad_s == 0, "R2", {tag, " sclk waveform"}, fa_s, fe_s);
    chk(bad_f == 0, "R5", {tag, " R4 R6 fsync waveform"}, fa_f, fe_f);
    chk(bad_t == 0, "R1", {tag, " R3 R7 txd waveform"}, fa_t, fe_t);
    chk(bad_b == 0, "R9", {tag, " busy while running"}, bad_b, 0);
    @(negedge clk);
    chk(sclk == clk_mode[1], "R9", {tag, " idle sclk"}, sclk, clk_mode[1]);
    chk(fsync == !fs_active_high, "R9", {tag, " idle fsync"}, fsync, !fs_active_high);
    chk(busy == 1'b0, "R9", {tag, " idle busy"}, busy, 0);
    chk(tx_underrun == (nfr > nw), "R10", {tag, " underrun flag"}, tx_underrun, nfr > nw);
    chk(rx_overrun == (nfr > DEPTH), "R11", {tag, " overrun flag"}, rx_overrun, nfr > DEPTH);
    nrx = (nfr < DEPTH) ? nfr : DEPTH;
    chk(rx_level == 4'(nrx), "R8", {tag, " rx_level"}, rx_level, nrx);
    for (int j = 0; j < nrx; j++) begin
      logic [31:0] ew;
      ew = (j < nw) ? (words[j] & msk) : 32'd0;
      chk(rx_not_empty && rx_data == ew, "R8", {tag, " rx word"}, rx_data, ew);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
    chk(rx_not_empty == 1'b0, "R8", {tag, " rx drained"}, rx_not_empty, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 0);
    do_reset();
    // reset state
    chk(sclk == 1'b0 && busy == 1'b0, "R9", "reset sclk/busy", {sclk, busy}, 0);
    chk(fsync == 1'b1, "R4", "reset fsync inactive (low polarity)", fsync, 1);
    chk(txd == 1'b0, "R7", "reset txd", txd, 0);
    chk(tx_not_full && tx_level == 0, "R12", "reset tx queue", tx_level, 0);
    chk(!rx_not_empty && rx_level == 0, "R8", "reset rx queue", rx_level, 0);
    chk(!tx_underrun && !rx_overrun, "R10", "reset flags R11", {tx_underrun, rx_overrun}, 0);

    // directed shapes
    set_cfg(0, 1, 1, 0, 1, 2, 0, 0, 0, 7, 0);  run_stream(3, 3, "base");
    set_cfg(1, 1, 0, 3, 2, 1, 0, 0, 0, 7, 0);  run_stream(2, 2, "mode1");
    set_cfg(2, 0, 2, 1, 1, 0, 1, 0, 0, 7, 0);  run_stream(2, 2, "mode2");
    set_cfg(3, 0, 0, 5, 3, 3, 0, 1, 0, 7, 0);  run_stream(2, 2, "mode3 eot");
    set_cfg(0, 1, 1, 0, 1, 3, 2, 0, 1, 7, 0);  run_stream(3, 3, "rel_lsb");
    set_cfg(2, 1, 0, 0, 3, 1, 0, 1, 1, 0, 0);  run_stream(3, 3, "rel_lsb w1 spill");
    set_cfg(1, 0, 3, 9, 0, 1, 1, 1, 0, 15, 1); run_stream(2, 2, "w32 fsw0");
    set_cfg(3, 1, 7, 126, 63, 3, 7, 0, 0, 0, 1); run_stream(2, 2, "w17 long");
    set_cfg(0, 0, 0, 0, 2, 0, 0, 1, 0, 0, 0);  run_stream(3, 3, "w1 minimal");
    // underrun: third frame has no word
    set_cfg(0, 1, 1, 2, 1, 1, 0, 0, 0, 5, 0);  run_stream(3, 2, "underrun R10");
    // nine pushes: ninth ignored, ninth frame underruns, its word overruns
    set_cfg(1, 1, 0, 0, 1, 0, 0, 0, 0, 3, 0);  run_stream(9, 9, "full R12 R11");
    clr_underrun = 1'b1; clr_overrun = 1'b1;
    @(negedge clk);
    clr_underrun = 1'b0; clr_overrun = 1'b0;
    chk(tx_underrun == 1'b0, "R10", "clear underrun", tx_underrun, 0);
    chk(rx_overrun == 1'b0, "R11", "clear overrun", rx_overrun, 0);

    // seeded random configurations
    for (int k = 0; k < 12; k++) begin
      int n;
      set_cfg($urandom % 4, $urandom % 2, $urandom % 8, $urandom % 128, $urandom % 64,
              $urandom % 4, $urandom % 8, $urandom % 2, $urandom % 2, $urandom % 16,
              $urandom % 2);
      n = 2 + ($urandom % 3);
      run_stream(n, n, "random");
    end
    finish_run();
  end

endmodule